// File: doc/BRIEF.md
# Vector Load/Store Execution Unit

This unit executes vector memory instructions one at a time. It takes a 32-bit instruction word and decodes it into one of four operation groups: a 128-bit vector load or store whose address is a base register plus a signed immediate, a 128-bit load or store whose address is the sum of two general registers, a load that reads one element and replicates it across the whole vector, and a store that writes one chosen element of a vector register. Operands come from a general-purpose register file and a 32-entry, 128-bit vector register file. Both are read combinationally in the cycle the instruction is accepted.

After it accepts an instruction, the unit computes the effective address and issues a single request on a valid/ready memory port that carries a 128-bit data bus and 16 byte strobes. It then writes any load result back to the vector register file. An instruction word that matches no supported pattern produces a one-cycle illegal flag and has no other effect. Caches, translation, alignment faults and enable checks are left to other blocks.

Top module: `vec_ldst_unit`

## Requirements
- R1: A word with bits[31:22]=0010110000 is a full load. Its address is GPR[bits 9:5] plus the sign-extended byte offset in bits[21:10]. All 16 strobes are asserted. Byte k of the response, which is the byte at address+k, is written to bits[8k+7:8k] of vector register bits[4:0].
- R2: A word with bits[31:22]=0010110001 is a full store. It uses the same address rule as R1. All 16 strobes are asserted, and bits[8k+7:8k] of vector register bits[4:0] go out as data byte k, which is stored at address+k.
- R3: A word with bits[31:15]=00111000010000000 is an indexed full load, and one with bits[31:15]=00111000010001000 is an indexed full store. The address is GPR[bits 9:5] + GPR[bits 14:10], and the data movement is the same as in R1 and R2.
- R4: Replicate loads read 2^s bytes and copy them into every lane of vector register bits[4:0]. The prefixes and offsets by size are: s=3, bits[31:19]=0011000000010, offset sext(bits[18:10])*8; s=2, bits[31:20]=001100000010, offset sext(bits[19:10])*4; s=1, bits[31:21]=00110000010, offset sext(bits[20:10])*2; s=0, bits[31:22]=0011000010, offset sext(bits[21:10]). Only the low 2^s strobes are asserted.
- R5: Element stores take the offset sext(bits[17:10]) << s and an element index placed directly above bit 17. The prefixes and index fields by size are: s=3, bits[31:19]=0011000100010 with index in bit 18; s=2, bits[31:20]=001100010010 with index in [19:18]; s=1, bits[31:21]=00110001010 with index in [20:18]; s=0, bits[31:22]=0011000110 with index in [21:18]. The element sits in data bytes 0..2^s-1, only those strobes are asserted, and no other memory byte changes.
- R6: Any other word raises illegal_o for exactly one cycle, in the cycle after acceptance. It issues no memory request and performs no vector register write.
- R7: While a request waits for mem_req_ready_i, its address, data, strobes and direction stay stable. No new instruction is accepted until the current one completes.
- R8: After reset the unit is ready, with no memory request, no vector write and no illegal flag.
- R9: Each load performs exactly one vector register write, and only after its response arrives. Stores and illegal words perform none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid_i | input | 1 | Instruction word present |
| instr_ready_o | output | 1 | Unit idle; instruction accepted when valid |
| instr_i | input | 32 | Instruction word |
| gpr_rj_idx_o | output | 5 | Base register index |
| gpr_rk_idx_o | output | 5 | Index register index |
| gpr_rj_data_i | input | 64 | Base register value |
| gpr_rk_data_i | input | 64 | Index register value |
| vrf_rd_idx_o | output | 5 | Vector register read index |
| vrf_rd_data_i | input | 128 | Vector register read value |
| vrf_we_o | output | 1 | Vector register write enable |
| vrf_wr_idx_o | output | 5 | Vector register write index |
| vrf_wr_data_o | output | 128 | Vector register write value |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_write_o | output | 1 | 1 = store, 0 = load |
| mem_req_addr_o | output | 64 | Byte address of data byte 0 |
| mem_req_wdata_o | output | 128 | Store data, byte k at address+k |
| mem_req_strb_o | output | 16 | Byte strobes, bit k for address+k |
| mem_rsp_valid_i | input | 1 | Load response valid |
| mem_rsp_data_i | input | 128 | Load data, byte k from address+k |
| illegal_o | output | 1 | Unrecognised instruction pulse |

## Verification
The assertions assume the memory side raises mem_rsp_valid_i exactly once for each accepted load request, never for a store and never while no load is outstanding. They also assume the register files answer combinationally in the same cycle. The stimulus meets these conditions with a memory model that answers every accepted read one cycle later and nothing else, and with register-file models that are plain arrays read through continuous assignments. Instructions are presented only while the unit is idle and are held for a single cycle. Request stalls come from a mode in which the model keeps ready low for two cycles of each request.

// File: rtl/vlsu_pkg.sv
package vlsu_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_LD_FULL = 3'd1,
        OP_ST_FULL = 3'd2,
        OP_LD_REPL = 3'd3,
        OP_ST_ELEM = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } esize_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_WB   = 2'd3
    } fsm_e;

    localparam int unsigned OFF_W = 16;

    typedef struct packed {
        op_e              op;
        esize_e           sz;
        logic             indexed;
        logic [OFF_W-1:0] offset;
        logic [3:0]       elem;
        logic [4:0]       rj;
        logic [4:0]       rk;
        logic [4:0]       vd;
        logic             legal;
    } dec_s;

endpackage

// File: rtl/vlsu_decode.sv
module vlsu_decode
    import vlsu_pkg::*;
(
    input  logic [31:0] instr_i,
    output dec_s        dec_o
);

    logic [OFF_W-1:0] off12, off11s1, off10s2, off9s3, off8;

    always_comb begin
        off12   = {{4{instr_i[21]}}, instr_i[21:10]};
        off11s1 = {{5{instr_i[20]}}, instr_i[20:10]} << 1;
        off10s2 = {{6{instr_i[19]}}, instr_i[19:10]} << 2;
        off9s3  = {{7{instr_i[18]}}, instr_i[18:10]} << 3;
        off8    = {{8{instr_i[17]}}, instr_i[17:10]};
    end

    always_comb begin
        dec_o    = '0;
        dec_o.rj = instr_i[9:5];
        dec_o.rk = instr_i[14:10];
        dec_o.vd = instr_i[4:0];
        if (instr_i[31:22] == 10'b0010110000) begin
            dec_o.op     = OP_LD_FULL;
            dec_o.offset = off12;
        end else if (instr_i[31:22] == 10'b0010110001) begin
            dec_o.op     = OP_ST_FULL;
            dec_o.offset = off12;
        end else if (instr_i[31:15] == 17'b00111000010000000) begin
            dec_o.op      = OP_LD_FULL;
            dec_o.indexed = 1'b1;
        end else if (instr_i[31:15] == 17'b00111000010001000) begin
            dec_o.op      = OP_ST_FULL;
            dec_o.indexed = 1'b1;
        end else if (instr_i[31:19] == 13'b0011000000010) begin
            dec_o.op     = OP_LD_REPL;
            dec_o.sz     = SZ_D;
            dec_o.offset = off9s3;
        end else if (instr_i[31:20] == 12'b001100000010) begin
            dec_o.op     = OP_LD_REPL;
            dec_o.sz     = SZ_W;
            dec_o.offset = off10s2;
        end else if (instr_i[31:21] == 11'b00110000010) begin
            dec_o.op     = OP_LD_REPL;
            dec_o.sz     = SZ_H;
            dec_o.offset = off11s1;
        end else if (instr_i[31:22] == 10'b0011000010) begin
            dec_o.op     = OP_LD_REPL;
            dec_o.sz     = SZ_B;
            dec_o.offset = off12;
        end else if (instr_i[31:19] == 13'b0011000100010) begin
            dec_o.op     = OP_ST_ELEM;
            dec_o.sz     = SZ_D;
            dec_o.elem   = {3'b000, instr_i[18]};
            dec_o.offset = off8 << 3;
        end else if (instr_i[31:20] == 12'b001100010010) begin
            dec_o.op     = OP_ST_ELEM;
            dec_o.sz     = SZ_W;
            dec_o.elem   = {2'b00, instr_i[19:18]};
            dec_o.offset = off8 << 2;
        end else if (instr_i[31:21] == 11'b00110001010) begin
            dec_o.op     = OP_ST_ELEM;
            dec_o.sz     = SZ_H;
            dec_o.elem   = {1'b0, instr_i[20:18]};
            dec_o.offset = off8 << 1;
        end else if (instr_i[31:22] == 10'b0011000110) begin
            dec_o.op     = OP_ST_ELEM;
            dec_o.sz     = SZ_B;
            dec_o.elem   = instr_i[21:18];
            dec_o.offset = off8;
        end
        dec_o.legal = (dec_o.op != OP_NONE);
    end

endmodule

// File: rtl/vlsu_agen.sv
module vlsu_agen #(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned OFF_W = 16
) (
    input  logic [XLEN-1:0]  base_i,
    input  logic [XLEN-1:0]  index_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic             indexed_i,
    output logic [XLEN-1:0]  addr_o
);

    localparam int unsigned EXT_W = XLEN - OFF_W;

    logic [XLEN-1:0] off_x;

    always_comb begin
        off_x  = {{EXT_W{off_i[OFF_W-1]}}, off_i};
        addr_o = base_i + (indexed_i ? index_i : off_x);
    end

endmodule

// File: rtl/vlsu_stpack.sv
module vlsu_stpack
    import vlsu_pkg::*;
#(
    parameter int unsigned VLEN = 128
) (
    input  op_e               op_i,
    input  esize_e            sz_i,
    input  logic [3:0]        elem_i,
    input  logic [VLEN-1:0]   vreg_i,
    output logic [VLEN-1:0]   wdata_o,
    output logic [VLEN/8-1:0] strb_o
);

    localparam int unsigned NB     = VLEN / 8;
    localparam int unsigned BOFF_W = $clog2(NB);

    logic [BOFF_W-1:0] boff;
    logic [VLEN-1:0]   shifted;
    logic              whole;

    always_comb begin
        boff    = BOFF_W'(elem_i) << sz_i;
        shifted = vreg_i >> {boff, 3'b000};
        whole   = (op_i == OP_LD_FULL) || (op_i == OP_ST_FULL);
    end

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic in_elem;
        assign in_elem   = (unsigned'(g) < (32'd1 << sz_i));
        assign strb_o[g] = whole || in_elem;
        assign wdata_o[8*g +: 8] = !strb_o[g] ? 8'h00 :
                                   whole      ? vreg_i[8*g +: 8] : shifted[8*g +: 8];
    end

endmodule

// File: rtl/vlsu_repl.sv
module vlsu_repl
    import vlsu_pkg::*;
#(
    parameter int unsigned VLEN = 128
) (
    input  esize_e          sz_i,
    input  logic [VLEN-1:0] rsp_i,
    output logic [VLEN-1:0] repl_o
);

    localparam int unsigned NB     = VLEN / 8;
    localparam int unsigned BOFF_W = $clog2(NB);

    logic [BOFF_W-1:0] lane_mask;

    assign lane_mask = BOFF_W'((32'd1 << sz_i) - 32'd1);

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [BOFF_W-1:0] src;
        assign src = BOFF_W'(g) & lane_mask;
        assign repl_o[8*g +: 8] = rsp_i[{src, 3'b000} +: 8];
    end

endmodule

// File: rtl/vec_ldst_unit.sv
module vec_ldst_unit
    import vlsu_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned VLEN = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid_i,
    output logic               instr_ready_o,
    input  logic [31:0]        instr_i,
    output logic [4:0]         gpr_rj_idx_o,
    output logic [4:0]         gpr_rk_idx_o,
    input  logic [XLEN-1:0]    gpr_rj_data_i,
    input  logic [XLEN-1:0]    gpr_rk_data_i,
    output logic [4:0]         vrf_rd_idx_o,
    input  logic [VLEN-1:0]    vrf_rd_data_i,
    output logic               vrf_we_o,
    output logic [4:0]         vrf_wr_idx_o,
    output logic [VLEN-1:0]    vrf_wr_data_o,
    output logic               mem_req_valid_o,
    input  logic               mem_req_ready_i,
    output logic               mem_req_write_o,
    output logic [XLEN-1:0]    mem_req_addr_o,
    output logic [VLEN-1:0]    mem_req_wdata_o,
    output logic [VLEN/8-1:0]  mem_req_strb_o,
    input  logic               mem_rsp_valid_i,
    input  logic [VLEN-1:0]    mem_rsp_data_i,
    output logic               illegal_o
);

    localparam int unsigned NB = VLEN / 8;

    typedef struct packed {
        fsm_e            state;
        logic            illegal;
        logic            wr;
        logic [XLEN-1:0] addr;
        logic [VLEN-1:0] wdata;
        logic [NB-1:0]   strb;
        logic [4:0]      vd;
        logic            repl;
        esize_e          sz;
        logic            we;
        logic [VLEN-1:0] wd;
    } regs_s;

    regs_s q, d;
    dec_s  dec;

    logic [XLEN-1:0] ea;
    logic [VLEN-1:0] st_wdata;
    logic [NB-1:0]   st_strb;
    logic [VLEN-1:0] repl_data;
    logic            is_store;

    vlsu_decode u_dec (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    vlsu_agen #(.XLEN(XLEN), .OFF_W(OFF_W)) u_agen (
        .base_i    (gpr_rj_data_i),
        .index_i   (gpr_rk_data_i),
        .off_i     (dec.offset),
        .indexed_i (dec.indexed),
        .addr_o    (ea)
    );

    vlsu_stpack #(.VLEN(VLEN)) u_stpack (
        .op_i    (dec.op),
        .sz_i    (dec.sz),
        .elem_i  (dec.elem),
        .vreg_i  (vrf_rd_data_i),
        .wdata_o (st_wdata),
        .strb_o  (st_strb)
    );

    vlsu_repl #(.VLEN(VLEN)) u_repl (
        .sz_i   (q.sz),
        .rsp_i  (mem_rsp_data_i),
        .repl_o (repl_data)
    );

    assign is_store = (dec.op == OP_ST_FULL) || (dec.op == OP_ST_ELEM);

    always_comb begin
        d         = q;
        d.illegal = 1'b0;
        d.we      = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (instr_valid_i) begin
                    if (!dec.legal) begin
                        d.illegal = 1'b1;
                    end else begin
                        d.state = ST_REQ;
                        d.wr    = is_store;
                        d.addr  = ea;
                        d.wdata = is_store ? st_wdata : '0;
                        d.strb  = st_strb;
                        d.vd    = dec.vd;
                        d.repl  = (dec.op == OP_LD_REPL);
                        d.sz    = dec.sz;
                    end
                end
            end
            ST_REQ: begin
                if (mem_req_ready_i) begin
                    d.state = q.wr ? ST_IDLE : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid_i) begin
                    d.state = ST_WB;
                    d.we    = 1'b1;
                    d.wd    = q.repl ? repl_data : mem_rsp_data_i;
                end
            end
            ST_WB: begin
                d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign instr_ready_o   = (q.state == ST_IDLE);
    assign gpr_rj_idx_o    = dec.rj;
    assign gpr_rk_idx_o    = dec.rk;
    assign vrf_rd_idx_o    = dec.vd;
    assign vrf_we_o        = q.we;
    assign vrf_wr_idx_o    = q.vd;
    assign vrf_wr_data_o   = q.wd;
    assign mem_req_valid_o = (q.state == ST_REQ);
    assign mem_req_write_o = q.wr;
    assign mem_req_addr_o  = q.addr;
    assign mem_req_wdata_o = q.wdata;
    assign mem_req_strb_o  = q.strb;
    assign illegal_o       = q.illegal;

    // R7: a stalled request keeps every field
    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && !mem_req_ready_i |=>
            mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_wdata_o) &&
            $stable(mem_req_strb_o) && $stable(mem_req_write_o));

    // R7: no acceptance while a request is outstanding
    a_r7_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> !instr_ready_o);

    // R6: the illegal flag comes with no side effect
    a_r6_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !mem_req_valid_o && !vrf_we_o);

    // R6: an unrecognised word accepted while idle raises the flag next cycle
    a_r6_illegal_raise: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid_i && instr_ready_o && !dec.legal |=> illegal_o);

    // R9: a vector write follows a memory response
    a_r9_we_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        vrf_we_o |-> $past(mem_rsp_valid_i));

    // R4/R5: strobes cover a power-of-two byte count
    a_r4_strb_shape: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> ($countones(mem_req_strb_o) inside {1, 2, 4, 8, 16}));

endmodule

// File: tb/sim_vec_ldst_unit.sv
module sim_vec_ldst_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         instr_valid = 1'b0;
    logic [31:0]  instr = 32'h0;
    logic         instr_ready;
    logic [4:0]   rj_idx, rk_idx, vrd_idx, vwr_idx;
    logic [63:0]  rj_data, rk_data;
    logic [127:0] vrd_data, vwr_data;
    logic         vwe;
    logic         req_valid, req_ready, req_write;
    logic [63:0]  req_addr;
    logic [127:0] req_wdata;
    logic [15:0]  req_strb;
    logic         rsp_valid = 1'b0;
    logic [127:0] rsp_data = '0;
    logic         illegal;

    logic [63:0]  gpr [32];
    logic [127:0] vrf [32];
    logic [7:0]   mem [256];

    int n_chk = 0, n_bad = 0;
    int we_cnt = 0, req_cnt = 0, wait_cnt = 0, stall_seen = 0, hold_err = 0, busy_err = 0;
    logic         stall_en = 1'b0;
    logic [63:0]  last_addr = '0;
    logic [15:0]  last_strb = '0;
    logic [127:0] last_wdata = '0;
    logic         prev_stall = 1'b0;
    logic [63:0]  p_addr = '0;
    logic [15:0]  p_strb = '0;
    logic [127:0] p_wdata = '0;
    logic         ill_seen = 1'b0, ill_after = 1'b0;

    always #2 clk = ~clk;

    vec_ldst_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .instr_valid_i(instr_valid), .instr_ready_o(instr_ready), .instr_i(instr),
        .gpr_rj_idx_o(rj_idx), .gpr_rk_idx_o(rk_idx),
        .gpr_rj_data_i(rj_data), .gpr_rk_data_i(rk_data),
        .vrf_rd_idx_o(vrd_idx), .vrf_rd_data_i(vrd_data),
        .vrf_we_o(vwe), .vrf_wr_idx_o(vwr_idx), .vrf_wr_data_o(vwr_data),
        .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready), .mem_req_write_o(req_write),
        .mem_req_addr_o(req_addr), .mem_req_wdata_o(req_wdata), .mem_req_strb_o(req_strb),
        .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data),
        .illegal_o(illegal)
    );

    assign rj_data   = gpr[rj_idx];
    assign rk_data   = gpr[rk_idx];
    assign vrd_data  = vrf[vrd_idx];
    assign req_ready = !stall_en || (wait_cnt >= 2);

    always @(posedge clk) begin
        if (vwe) begin
            vrf[vwr_idx] <= vwr_data;
            we_cnt <= we_cnt + 1;
        end
    end

    always @(posedge clk) begin
        rsp_valid <= 1'b0;
        if (req_valid && req_ready) begin
            req_cnt    <= req_cnt + 1;
            last_addr  <= req_addr;
            last_strb  <= req_strb;
            last_wdata <= req_wdata;
            for (int k = 0; k < 16; k++) begin
                if (req_write) begin
                    if (req_strb[k]) mem[8'(req_addr[7:0] + 8'(k))] <= req_wdata[8*k +: 8];
                end else begin
                    rsp_data[8*k +: 8] <= mem[8'(req_addr[7:0] + 8'(k))];
                end
            end
            if (!req_write) rsp_valid <= 1'b1;
        end
        if (req_valid && !req_ready) begin
            wait_cnt   <= wait_cnt + 1;
            stall_seen <= stall_seen + 1;
        end else begin
            wait_cnt <= 0;
        end
        if (rst_n && prev_stall &&
            (!req_valid || req_addr != p_addr || req_strb != p_strb || req_wdata != p_wdata))
            hold_err <= hold_err + 1;
        prev_stall <= req_valid && !req_ready;
        p_addr     <= req_addr;
        p_strb     <= req_strb;
        p_wdata    <= req_wdata;
    end

    always @(negedge clk) begin
        if (rst_n && req_valid && instr_ready) busy_err <= busy_err + 1;
    end

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(logic [63:0] a, int k);
        return mem[8'(a[7:0] + 8'(k))];
    endfunction

    function automatic logic [127:0] mem128(logic [63:0] a);
        logic [127:0] v;
        for (int k = 0; k < 16; k++) v[8*k +: 8] = mbyte(a, k);
        return v;
    endfunction

    task automatic issue(logic [31:0] w);
        @(negedge clk);
        instr = w;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        ill_seen = illegal;
        for (int i = 0; i < 200 && !instr_ready; i++) @(negedge clk);
        @(negedge clk);
        ill_after = illegal;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R8 ready", 128'(instr_ready), 128'd1);
        chk("R8 no req", 128'(req_valid), 128'd0);
        chk("R8 no write", 128'(vwe), 128'd0);
        chk("R8 no illegal", 128'(illegal), 128'd0);
    endtask

    task automatic t_load_full(int vd, int rj, logic [63:0] base, logic [11:0] imm);
        logic [63:0]  ea;
        logic [127:0] exp;
        int w0;
        gpr[rj] = base;
        ea  = base + {{52{imm[11]}}, imm};
        exp = mem128(ea);
        w0  = we_cnt;
        issue({10'b0010110000, imm, 5'(rj), 5'(vd)});
        chk("R1 data", vrf[vd], exp);
        chk("R1 addr", 128'(last_addr), 128'(ea));
        chk("R1 strb", 128'(last_strb), 128'hFFFF);
        chk("R9 one write per load", 128'(we_cnt - w0), 128'd1);
    endtask

    task automatic t_store_full(int vd, int rj, logic [63:0] base, logic [11:0] imm);
        logic [63:0] ea;
        int w0;
        gpr[rj] = base;
        ea = base + {{52{imm[11]}}, imm};
        w0 = we_cnt;
        issue({10'b0010110001, imm, 5'(rj), 5'(vd)});
        chk("R2 memory", mem128(ea), vrf[vd]);
        chk("R2 addr", 128'(last_addr), 128'(ea));
        chk("R2 strb", 128'(last_strb), 128'hFFFF);
        chk("R9 store no write", 128'(we_cnt - w0), 128'd0);
    endtask

    task automatic t_indexed;
        logic [127:0] exp;
        gpr[4] = 64'h20; gpr[5] = 64'h30;
        exp = mem128(64'h50);
        issue({17'b00111000010000000, 5'd5, 5'd4, 5'd9});
        chk("R3 indexed load data", vrf[9], exp);
        chk("R3 indexed load addr", 128'(last_addr), 128'h50);
        gpr[6] = 64'h90; gpr[7] = 64'h10;
        issue({17'b00111000010001000, 5'd7, 5'd6, 5'd2});
        chk("R3 indexed store mem", mem128(64'hA0), vrf[2]);
        chk("R3 indexed store addr", 128'(last_addr), 128'hA0);
    endtask

    task automatic t_repl(int s, int vd, logic [63:0] base, int field);
        logic [31:0]  w;
        logic [63:0]  ea;
        logic [127:0] exp;
        int n;
        n = 1 << s;
        gpr[3] = base;
        ea = base + 64'(longint'(field) * n);
        case (s)
            3: w = {13'b0011000000010, 9'(field), 5'd3, 5'(vd)};
            2: w = {12'b001100000010, 10'(field), 5'd3, 5'(vd)};
            1: w = {11'b00110000010, 11'(field), 5'd3, 5'(vd)};
            default: w = {10'b0011000010, 12'(field), 5'd3, 5'(vd)};
        endcase
        for (int k = 0; k < 16; k++) exp[8*k +: 8] = mbyte(ea, k % n);
        issue(w);
        chk($sformatf("R4 replicate s=%0d data", s), vrf[vd], exp);
        chk($sformatf("R4 replicate s=%0d addr", s), 128'(last_addr), 128'(ea));
        chk($sformatf("R4 replicate s=%0d strb", s), 128'(last_strb), 128'((1 << n) - 1));
    endtask

    task automatic t_elem(int s, int vd, logic [63:0] base, int off, int idx);
        logic [31:0] w;
        logic [63:0] ea;
        logic [7:0]  below, above;
        int n;
        n = 1 << s;
        gpr[8] = base;
        ea = base + 64'(longint'(off) * n);
        case (s)
            3: w = {13'b0011000100010, 1'(idx), 8'(off), 5'd8, 5'(vd)};
            2: w = {12'b001100010010, 2'(idx), 8'(off), 5'd8, 5'(vd)};
            1: w = {11'b00110001010, 3'(idx), 8'(off), 5'd8, 5'(vd)};
            default: w = {10'b0011000110, 4'(idx), 8'(off), 5'd8, 5'(vd)};
        endcase
        below = mbyte(ea, -1);
        above = mbyte(ea, n);
        issue(w);
        for (int k = 0; k < n; k++)
            chk($sformatf("R5 element s=%0d byte %0d", s, k), 128'(mbyte(ea, k)),
                128'(vrf[vd][8*(idx*n + k) +: 8]));
        chk($sformatf("R5 element s=%0d byte below", s), 128'(mbyte(ea, -1)), 128'(below));
        chk($sformatf("R5 element s=%0d byte above", s), 128'(mbyte(ea, n)), 128'(above));
        chk($sformatf("R5 element s=%0d addr", s), 128'(last_addr), 128'(ea));
        chk($sformatf("R5 element s=%0d strb", s), 128'(last_strb), 128'((1 << n) - 1));
    endtask

    task automatic t_illegal(logic [31:0] w);
        int r0, w0;
        r0 = req_cnt; w0 = we_cnt;
        issue(w);
        chk("R6 illegal pulse", 128'(ill_seen), 128'd1);
        chk("R6 pulse one cycle", 128'(ill_after), 128'd0);
        chk("R6 no request", 128'(req_cnt - r0), 128'd0);
        chk("R9 illegal no write", 128'(we_cnt - w0), 128'd0);
    endtask

    task automatic t_stall;
        int s0;
        s0 = stall_seen;
        stall_en = 1'b1;
        t_store_full(12, 1, 64'hC0, 12'h000);
        t_load_full(13, 1, 64'hC0, 12'h000);
        stall_en = 1'b0;
        chk("R7 stall observed", 128'(stall_seen - s0 >= 4), 128'd1);
        chk("R7 request held", 128'(hold_err), 128'd0);
        chk("R7 no accept while busy", 128'(busy_err), 128'd0);
        chk("R7 stalled round trip", vrf[13], vrf[12]);
    endtask

    task automatic finish_sim;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
        for (int i = 0; i < 32; i++) begin
            gpr[i] = 64'(i * 16);
            vrf[i] = {4{32'(32'hA5000000 + i * 32'h01030507)}} ^ 128'(i * 64'h0F0E0D0C0B0A0908);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_full(10, 1, 64'h40, 12'h010);
        t_load_full(11, 2, 64'h80, 12'hFE0);
        t_store_full(3, 1, 64'h10, 12'h008);
        t_indexed();
        t_repl(3, 14, 64'h40, -1);
        t_repl(2, 15, 64'h20, 3);
        t_repl(1, 16, 64'h60, -2);
        t_repl(0, 17, 64'h30, 5);
        t_elem(3, 20, 64'hE0, -2, 1);
        t_elem(2, 21, 64'h70, -2, 3);
        t_elem(1, 22, 64'hB0, 3, 7);
        t_elem(0, 23, 64'hD0, -5, 15);
        t_illegal(32'hFFFF_FFFF);
        t_illegal(32'h0000_0000);
        t_stall();
        finish_sim();
    end

endmodule